// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block sits between the internal bus and the external access sequencer. It holds a description of eight address areas. Each area has a base address, a power-of-two size, and a set of access attributes. For every bus request it picks at most one area and drives that area's active-low chip select. It also hands the area's timing type, data width, byte order and burst limit to the sequencer.

A request can be refused because no enabled area covers the address, or because it writes into a write-protected area. A refused request gets an error flag and drives no chip select. The sequencer can then end the access without touching the external bus.

Software sets up the areas through a small write-only register port. Each area has one attribute word and one base word. All decode results are registered, so the sequencer sees the answer one clock after it presents the request.

Top module: `csDecoder`

## Requirements
- R1: Outputs are registered. A request presented in one cycle is answered in the next cycle with rspValid high. A cycle with reqValid low yields rspValid low, rspErr low and all csN bits high in the following cycle.
- R2: An area of size code s (0..15) spans 64 KB << s bytes, so code 15 gives 2 GB. An address matches the area when reqAddr bits above the size equal the same bits of the stored base. Base bits below the size are ignored.
- R3: When several enabled areas match, the lowest-numbered one wins. Only its csN bit goes low, and rspArea carries its number.
- R4: A disabled area never matches. An address covered by no enabled area gives rspErr high with all csN bits high.
- R5: A write whose winning area is write-protected gives rspErr high with all csN bits high. A read of the same area is granted normally.
- R6: On a granted request, rspTiming, rspWide and rspLittle carry the winning area's stored values, and rspBurstBeats equals 1 << burst code (1, 2, 4 or 8). On a refused or idle cycle, all attribute outputs and rspArea are zero.
- R7: Area 0 always reports rspLittle low, whatever its stored byte-order bit.
- R8: Register port layout. cfgAddr[3:1] selects the area. cfgAddr[0]=0 selects the attribute word: bit0 enable, bit1 write-protect, bit2 little-endian, bit3 16-bit width, bits[5:4] burst code, bits[8:6] timing type, bits[19:16] size code. cfgAddr[0]=1 selects the base word, whose bits[31:16] are the base. A write with cfgWe high takes effect for a request presented in the next cycle.
- R9: After reset every area is disabled, so every request is refused until one is configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Area number and word select |
| cfgWdata | input | 32 | Configuration write data |
| reqValid | input | 1 | Bus request present |
| reqWrite | input | 1 | Request is a write |
| reqAddr | input | 32 | Request byte address |
| csN | output | 8 | Active-low chip selects, one per area |
| rspValid | output | 1 | Decode result valid |
| rspErr | output | 1 | Request refused |
| rspArea | output | 3 | Winning area number |
| rspTiming | output | 3 | Timing type of winning area |
| rspWide | output | 1 | Winning area is 16 bits wide |
| rspLittle | output | 1 | Winning area is little-endian |
| rspBurstBeats | output | 4 | Maximum burst length in beats |

## Verification
A corrupted base, size or enable bit in one area changes the chip select or error flag on the very next response. It shows only for addresses near that area's boundaries or in its overlap with another area. The bench therefore sweeps every 64 KB tile of a low window, for both reads and writes, against a layout with overlapping, disabled, protected and misaligned-base areas. A fault in the priority encoder or output register shows as two chip selects, or a chip select beside an error, one cycle after the request.

// File: rtl/csDecPkg.sv
package csDecPkg;
  parameter int AREAS = 8;
  parameter int IDX_W = $clog2(AREAS);
  parameter int SIZE_W = 4;
  parameter int TIMING_W = 3;
  parameter int BURST_W = 2;

  typedef struct packed {
    logic [SIZE_W-1:0]   sizeCode;
    logic [TIMING_W-1:0] timing;
    logic [BURST_W-1:0]  burst;
    logic                wide;
    logic                little;
    logic                writeProt;
    logic                enable;
  } areaAttr_t;

  typedef struct packed {
    logic             capture;
    logic             grant;
    logic [IDX_W-1:0] winIdx;
  } decStrobe_t;
endpackage

// File: rtl/csDecDatapath.sv
module csDecDatapath
  import csDecPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRAN_BITS = 16,
  localparam int TAG_W = ADDR_W - GRAN_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [IDX_W:0]      cfgAddr,
  input  logic [ADDR_W-1:0]   cfgWdata,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  decStrobe_t          strobe,
  output logic [AREAS-1:0]    hitVec,
  output logic [AREAS-1:0]    protVec,
  output logic [AREAS-1:0]    csN,
  output logic                rspValid,
  output logic                rspErr,
  output logic [IDX_W-1:0]    rspArea,
  output logic [TIMING_W-1:0] rspTiming,
  output logic                rspWide,
  output logic                rspLittle,
  output logic [(1<<BURST_W)-1:0] rspBurstBeats
);
  areaAttr_t attrs [AREAS];
  logic [TAG_W-1:0] bases [AREAS];
  logic [TAG_W-1:0] reqTag;
  logic cfgUnused;

  assign reqTag = reqAddr[ADDR_W-1:GRAN_BITS];
  assign cfgUnused = ^{cfgWdata[15:9], cfgWdata[ADDR_W-1:20], reqAddr[GRAN_BITS-1:0]};

  for (genvar a = 0; a < AREAS; a++) begin : gArea
    logic [TAG_W-1:0] keepMask;
    logic attrSel, baseSel;
    assign attrSel = cfgWe && (cfgAddr[IDX_W:1] == IDX_W'(a)) && !cfgAddr[0];
    assign baseSel = cfgWe && (cfgAddr[IDX_W:1] == IDX_W'(a)) && cfgAddr[0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        attrs[a] <= '0;
        bases[a] <= '0;
      end else begin
        if (attrSel) begin
          attrs[a].enable    <= cfgWdata[0];
          attrs[a].writeProt <= cfgWdata[1];
          attrs[a].little    <= cfgWdata[2];
          attrs[a].wide      <= cfgWdata[3];
          attrs[a].burst     <= cfgWdata[5:4];
          attrs[a].timing    <= cfgWdata[8:6];
          attrs[a].sizeCode  <= cfgWdata[19:16];
        end
        if (baseSel) bases[a] <= cfgWdata[ADDR_W-1:GRAN_BITS];
      end
    end

    assign keepMask   = {TAG_W{1'b1}} << attrs[a].sizeCode;
    assign hitVec[a]  = attrs[a].enable && (((reqTag ^ bases[a]) & keepMask) == '0);
    assign protVec[a] = attrs[a].writeProt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN           <= '1;
      rspValid      <= 1'b0;
      rspErr        <= 1'b0;
      rspArea       <= '0;
      rspTiming     <= '0;
      rspWide       <= 1'b0;
      rspLittle     <= 1'b0;
      rspBurstBeats <= '0;
    end else begin
      rspValid <= strobe.capture;
      rspErr   <= strobe.capture && !strobe.grant;
      if (strobe.grant) begin
        csN           <= ~(AREAS'(1) << strobe.winIdx);
        rspArea       <= strobe.winIdx;
        rspTiming     <= attrs[strobe.winIdx].timing;
        rspWide       <= attrs[strobe.winIdx].wide;
        rspLittle     <= attrs[strobe.winIdx].little && (strobe.winIdx != '0);
        rspBurstBeats <= (1<<BURST_W)'(1) << attrs[strobe.winIdx].burst;
      end else begin
        csN           <= '1;
        rspArea       <= '0;
        rspTiming     <= '0;
        rspWide       <= 1'b0;
        rspLittle     <= 1'b0;
        rspBurstBeats <= '0;
      end
    end
  end
endmodule

// File: rtl/csDecCtrl.sv
module csDecCtrl
  import csDecPkg::*;
(
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [AREAS-1:0] hitVec,
  input  logic [AREAS-1:0] protVec,
  output decStrobe_t       strobe
);
  logic [IDX_W-1:0] winIdx;
  logic anyHit, refused;

  always_comb begin
    winIdx = '0;
    for (int i = AREAS - 1; i >= 0; i--) begin
      if (hitVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyHit  = |hitVec;
  assign refused = !anyHit || (reqWrite && protVec[winIdx]);

  assign strobe.capture = reqValid;
  assign strobe.grant   = reqValid && !refused;
  assign strobe.winIdx  = winIdx;
endmodule

// File: rtl/csDecoder.sv
module csDecoder
  import csDecPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRAN_BITS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [IDX_W:0]      cfgAddr,
  input  logic [ADDR_W-1:0]   cfgWdata,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic [AREAS-1:0]    csN,
  output logic                rspValid,
  output logic                rspErr,
  output logic [IDX_W-1:0]    rspArea,
  output logic [TIMING_W-1:0] rspTiming,
  output logic                rspWide,
  output logic                rspLittle,
  output logic [(1<<BURST_W)-1:0] rspBurstBeats
);
  logic [AREAS-1:0] hitVec, protVec;
  decStrobe_t strobe;

  csDecCtrl uCtrl (
    .reqValid(reqValid), .reqWrite(reqWrite),
    .hitVec(hitVec), .protVec(protVec), .strobe(strobe)
  );

  csDecDatapath #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) uPath (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .reqAddr(reqAddr), .strobe(strobe),
    .hitVec(hitVec), .protVec(protVec),
    .csN(csN), .rspValid(rspValid), .rspErr(rspErr), .rspArea(rspArea),
    .rspTiming(rspTiming), .rspWide(rspWide), .rspLittle(rspLittle),
    .rspBurstBeats(rspBurstBeats)
  );
endmodule

// File: rtl/csDecChecker.sv
module csDecChecker
  import csDecPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [AREAS-1:0]    csN,
  input logic                rspValid,
  input logic                rspErr,
  input logic [IDX_W-1:0]    rspArea,
  input logic                rspLittle,
  input logic [(1<<BURST_W)-1:0] rspBurstBeats
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspErr && (&csN)));

  assert_answer_next_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_single_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_select_matches_area_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspErr) |-> !csN[rspArea]);

  assert_refused_no_select_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (&csN));

  assert_burst_power_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspErr) |-> ($countones(rspBurstBeats) == 1));

  assert_area0_big_R7: assert property (@(posedge clk) disable iff (!rstN)
    !csN[0] |-> !rspLittle);
endmodule

bind csDecoder csDecChecker uChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .csN(csN),
  .rspValid(rspValid), .rspErr(rspErr), .rspArea(rspArea),
  .rspLittle(rspLittle), .rspBurstBeats(rspBurstBeats)
);

// File: tb/tb_csDecoder.sv
`timescale 1ns/1ps
module tb_csDecoder;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0] csN;
  logic rspValid, rspErr, rspWide, rspLittle;
  logic [2:0] rspArea, rspTiming;
  logic [3:0] rspBurstBeats;

  int errors = 0, checks = 0;
  bit mEn[8], mWp[8], mLit[8], mWide[8];
  int mBurst[8], mTim[8], mSize[8];
  logic [31:0] mBase[8];

  always #2.5 clk = ~clk;

  csDecoder dut (.*);

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setAttr(input int a, input bit en, input bit wp, input bit lit,
                         input bit wide, input int burst, input int tim, input int size);
    mEn[a] = en; mWp[a] = wp; mLit[a] = lit; mWide[a] = wide;
    mBurst[a] = burst; mTim[a] = tim; mSize[a] = size;
    cfgWe = 1'b1; cfgAddr = {3'(a), 1'b0};
    cfgWdata = (32'(size) << 16) | (32'(tim) << 6) | (32'(burst) << 4)
             | (32'(wide) << 3) | (32'(lit) << 2) | (32'(wp) << 1) | 32'(en);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setBase(input int a, input logic [31:0] base);
    mBase[a] = base;
    cfgWe = 1'b1; cfgAddr = {3'(a), 1'b1}; cfgWdata = base;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic access(input logic [31:0] addr, input bit wr);
    int win;
    bit err;
    logic [31:0] mask;
    string tag;
    win = -1;
    for (int a = 7; a >= 0; a--) begin
      mask = 32'hFFFF_FFFF << (16 + mSize[a]);
      if (mEn[a] && ((addr & mask) == (mBase[a] & mask))) win = a;
    end
    err = (win < 0) || (wr && mWp[win]);
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    if (err) begin
      tag = (win >= 0) ? "R5" : "R4";
      check(tag, {rspValid, rspErr, csN}, {1'b1, 1'b1, 8'hFF});
      check("R6", {rspArea, rspTiming, rspWide, rspLittle, rspBurstBeats}, '0);
    end else begin
      tag = (win == 0) ? "R7" : ((mSize[win] > 0) ? "R2" : "R3");
      check(tag, {rspValid, rspErr, csN, rspArea},
            {1'b1, 1'b0, ~(8'd1 << win), 3'(win)});
      check("R6", {rspTiming, rspWide, rspLittle, rspBurstBeats},
            {3'(mTim[win]), mWide[win], (mLit[win] && win != 0), 4'(1 << mBurst[win])});
    end
  endtask

  initial begin
    for (int a = 0; a < 8; a++) begin
      mEn[a] = 0; mWp[a] = 0; mLit[a] = 0; mWide[a] = 0;
      mBurst[a] = 0; mTim[a] = 0; mSize[a] = 0; mBase[a] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {rspValid, rspErr, csN}, {1'b0, 1'b0, 8'hFF});
    access(32'h0000_0000, 0);   // R9: nothing enabled yet
    access(32'h8000_1234, 1);   // R9
    @(negedge clk);
    check("R1", {rspValid, rspErr, csN}, {1'b0, 1'b0, 8'hFF});

    setAttr(0, 1, 0, 1, 0, 3, 1, 0);  setBase(0, 32'h0000_0000);
    setAttr(1, 1, 0, 1, 1, 1, 2, 0);  setBase(1, 32'h0001_0000);
    setAttr(2, 1, 0, 0, 1, 2, 3, 4);  setBase(2, 32'h0010_0000);
    setAttr(3, 1, 0, 1, 0, 0, 4, 3);  setBase(3, 32'h0018_0000);
    setAttr(4, 0, 0, 0, 1, 1, 5, 0);  setBase(4, 32'h0020_0000);
    setAttr(5, 1, 1, 1, 1, 3, 6, 1);  setBase(5, 32'h0030_0000);
    setAttr(6, 1, 0, 0, 0, 2, 7, 15); setBase(6, 32'h8000_0000);
    setAttr(7, 1, 0, 1, 1, 1, 2, 2);  setBase(7, 32'h0041_0000);

    for (int t = 0; t < 96; t++) begin
      access((32'(t) << 16) | ((32'(t) * 32'h1357) & 32'hFFFF), 0);
      access((32'(t) << 16) | 32'hFFFE, 1);
    end
    for (int t = 0; t < 16; t++) begin
      access(32'h8000_0000 + (32'(t) << 27) + 32'(t), t[0]);
      access(32'h6000_0000 + (32'(t) << 24), 0);
    end

    // R8: reconfigure, effective on the very next request
    setAttr(2, 0, 0, 0, 1, 2, 3, 4);
    for (int t = 16; t < 32; t++) access(32'(t) << 16, 0);
    setAttr(4, 1, 0, 1, 1, 1, 5, 0);
    access(32'h0020_8000, 0);
    setBase(4, 32'h0050_0000);
    access(32'h0020_8000, 0);
    access(32'h0050_0004, 1);
    setAttr(0, 1, 1, 1, 0, 3, 1, 0);
    access(32'h0000_0010, 1);   // R5 on area 0
    access(32'h0000_0010, 0);
    @(negedge clk);
    check("R1", {rspValid, rspErr, csN}, {1'b0, 1'b0, 8'hFF});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule